// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes one instruction in every clock cycle. It supports eight instructions: register-to-register add, subtract, bitwise AND, bitwise OR and signed set-less-than, plus load word, store word and branch-if-equal. A program counter fetches from an internal instruction store. A decoder turns the opcode into a fixed control word for each instruction class. The control word picks the destination register field, the second ALU operand, the write-back source and the next PC. The 32-entry register file, the instruction store and the data store all read combinationally and write only on the rising clock edge.

The stores are loaded through a preload port, normally while reset is held. Each cycle the core places its register write-back and its data-store write on output ports, so a surrounding environment can follow execution without looking inside the block. A synchronous active-high reset returns the PC to zero and blocks all architectural writes.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `wb_en_o` and `st_en_o` are 0. The first rising edge with `rst` high sets `pc_o` to 0.
- R2: Every instruction other than a taken branch advances `pc_o` by 4 at the next rising edge.
- R3: With opcode 0x00 the destination is bits [15:11], the sources are bits [25:21] and [20:16], and bits [10:6] must be 0. The funct field, bits [5:0], selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (the result is 1 or 0).
- R4: Opcode 0x23 (load word) writes the register named by bits [20:16] with the data word at byte address R[bits 25:21] + sign-extended bits [15:0].
- R5: Opcode 0x2B (store word) writes R[bits 20:16] to the data word at the same computed address. It shows `st_en_o`=1 with that address and data, keeps `wb_en_o` at 0, and a later load of that address returns the stored word.
- R6: Opcode 0x04 (branch-if-equal) makes no register or memory write. When the two source registers are equal, the next PC is PC+4+(sign-extended immediate × 4). Otherwise the next PC is PC+4. An offset of -1 holds the PC in place.
- R7: Register 0 always reads as zero. A write aimed at it is visible on the write-back port but has no effect.
- R8: Any opcode other than 0x00, 0x23, 0x2B and 0x04 only advances the PC. An opcode-0x00 word with an unlisted funct or a nonzero bits [10:6] writes nothing.
- R9: An instruction whose destination is one of its own sources reads the old value. The next instruction sees the new one.
- R10: Memories hold words and are indexed by byte-address bits [AW+1:2]. The preload port writes the instruction store (`ld_dmem`=0) or the data store (`ld_dmem`=1) at word index `ld_addr` on a rising edge, and the contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 0 instruction store, 1 data store |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload data word |
| pc_o | output | 32 | Address of the instruction now executing |
| wb_en_o | output | 1 | Register write this cycle |
| wb_reg_o | output | 5 | Register being written |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | Data-store write this cycle |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Data being stored |

## Verification
The register file is read and written in the same cycle when an instruction names its own destination as a source. This happens in `add r1,r1,r1`. The check looks at the write-back data, which must be twice the old value. The next instruction must then read the doubled value. A second overlap is a store followed at once by a load of the same word, where the load must return what the store wrote one edge earlier. A taken branch, a not-taken branch and a self-loop branch are placed so that the PC checks show both the redirect and the skipped instruction's missing write.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN = 32;
    localparam int RIDX_W = 5;

    typedef logic [XLEN-1:0] word_t;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_fn_t;

    typedef struct packed {
        logic       dst_is_rd;
        logic       reg_write;
        logic       b_is_imm;
        logic       branch;
        logic       wb_from_mem;
        logic       mem_read;
        logic       mem_write;
        logic [1:0] alu_class;
    } ctrl_t;

    typedef struct packed {
        word_t pc;
    } core_state_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  word_t   instr,
    output ctrl_t   ctl,
    output alu_fn_t fn,
    output logic    fn_ok
);
    logic [5:0] opcode;
    logic [5:0] funct;
    logic [4:0] shamt;

    assign opcode = instr[31:26];
    assign funct  = instr[5:0];
    assign shamt  = instr[10:6];

    always_comb begin
        ctl = '0;
        unique case (opcode)
            OPC_RTYPE: begin
                ctl.dst_is_rd = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.alu_class = 2'b10;
            end
            OPC_LOAD: begin
                ctl.reg_write   = 1'b1;
                ctl.b_is_imm    = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.mem_read    = 1'b1;
            end
            OPC_STORE: begin
                ctl.b_is_imm  = 1'b1;
                ctl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctl.branch    = 1'b1;
                ctl.alu_class = 2'b01;
            end
            default: ctl = '0;
        endcase
    end

    always_comb begin
        fn    = ALU_ADD;
        fn_ok = 1'b1;
        unique case (ctl.alu_class)
            2'b01: fn = ALU_SUB;
            2'b10: begin
                fn_ok = (shamt == '0);
                unique case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn_ok = 1'b0;
                endcase
            end
            default: fn = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  word_t   a,
    input  word_t   b,
    input  alu_fn_t fn,
    output word_t   y,
    output logic    zero
);
    always_comb begin
        unique case (fn)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int NREGS = 32
) (
    input  logic              clk,
    input  logic [RIDX_W-1:0] ra,
    input  logic [RIDX_W-1:0] rb,
    input  logic              we,
    input  logic [RIDX_W-1:0] wa,
    input  word_t             wd,
    output word_t             qa,
    output word_t             qb
);
    word_t regs_d [NREGS];
    word_t regs_q [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign qa = (ra == '0) ? '0 : regs_q[ra];
    assign qb = (rb == '0) ? '0 : regs_q[rb];
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem
    import sc_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t mem_d [WORDS];
    word_t mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = re ? mem_q[raddr] : '0;
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW   = $clog2(IMEM_WORDS),
    localparam int DAW   = $clog2(DMEM_WORDS),
    localparam int LD_AW = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_dmem,
    input  logic [LD_AW-1:0]  ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   pc_o,
    output logic              wb_en_o,
    output logic [RIDX_W-1:0] wb_reg_o,
    output logic [XLEN-1:0]   wb_data_o,
    output logic              st_en_o,
    output logic [XLEN-1:0]   st_addr_o,
    output logic [XLEN-1:0]   st_data_o
);
    core_state_t st_d, st_q;

    word_t   instr, rd_a, rd_b, simm, alu_b, alu_y, mem_rd, wb_val;
    word_t   pc_plus4, br_tgt;
    logic    alu_zero, wb_en, store_en, pre_d;
    logic [RIDX_W-1:0] wb_reg;
    ctrl_t   ctl;
    alu_fn_t fn;
    logic    fn_ok;

    sc_wordmem #(.WORDS(IMEM_WORDS)) u_imem (
        .clk   (clk),
        .we    (ld_en & ~ld_dmem),
        .waddr (ld_addr[IAW-1:0]),
        .wdata (ld_data),
        .re    (1'b1),
        .raddr (st_q.pc[IAW+1:2]),
        .rdata (instr)
    );

    sc_decode u_dec (
        .instr (instr),
        .ctl   (ctl),
        .fn    (fn),
        .fn_ok (fn_ok)
    );

    assign wb_reg = ctl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign wb_en  = ctl.reg_write & fn_ok & ~rst;

    sc_regfile #(.NREGS(32)) u_rf (
        .clk (clk),
        .ra  (instr[25:21]),
        .rb  (instr[20:16]),
        .we  (wb_en),
        .wa  (wb_reg),
        .wd  (wb_val),
        .qa  (rd_a),
        .qb  (rd_b)
    );

    assign simm  = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign alu_b = ctl.b_is_imm ? simm : rd_b;

    sc_alu u_alu (
        .a    (rd_a),
        .b    (alu_b),
        .fn   (fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign store_en = ctl.mem_write & ~rst;
    assign pre_d    = ld_en & ld_dmem;

    sc_wordmem #(.WORDS(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .we    (pre_d | store_en),
        .waddr (pre_d ? ld_addr[DAW-1:0] : alu_y[DAW+1:2]),
        .wdata (pre_d ? ld_data : rd_b),
        .re    (ctl.mem_read),
        .raddr (alu_y[DAW+1:2]),
        .rdata (mem_rd)
    );

    assign wb_val = ctl.wb_from_mem ? mem_rd : alu_y;

    always_comb begin
        pc_plus4 = st_q.pc + 32'd4;
        br_tgt   = pc_plus4 + {simm[XLEN-3:0], 2'b00};
        st_d     = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (ctl.branch && alu_zero) begin
            st_d.pc = br_tgt;
        end else begin
            st_d.pc = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o      = st_q.pc;
    assign wb_en_o   = wb_en;
    assign wb_reg_o  = wb_reg;
    assign wb_data_o = wb_val;
    assign st_en_o   = store_en;
    assign st_addr_o = alu_y;
    assign st_data_o = rd_b;
endmodule

// File: rtl/sc_core_checker.sv
module sc_core_checker
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input word_t       pc,
    input logic [5:0]  op,
    input logic [4:0]  rs_idx,
    input word_t       rs_val,
    input logic        srcs_equal,
    input logic [15:0] imm,
    input logic        wb_en,
    input logic        st_en
);
    logic  seen_q = 1'b0;
    word_t tgt;

    always_ff @(posedge clk) begin
        seen_q <= 1'b1;
    end

    assign tgt = pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};

    assert_reset_pc_R1: assert property (@(posedge clk)
        (seen_q && $past(rst)) |-> (pc == '0));

    assert_no_write_in_reset_R1: assert property (@(posedge clk)
        rst |-> (!wb_en && !st_en));

    assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(rst) && ($past(op) != OPC_BEQ)) |-> (pc == $past(pc) + 32'd4));

    assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
        st_en |-> !wb_en);

    assert_beq_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ && srcs_equal) |=> (pc == $past(tgt)));

    assert_beq_not_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ && !srcs_equal) |=> (pc == $past(pc) + 32'd4));

    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == '0) |-> (rs_val == '0));

    assert_nop_opcode_R8: assert property (@(posedge clk) disable iff (rst)
        (op != OPC_RTYPE && op != OPC_LOAD && op != OPC_STORE && op != OPC_BEQ)
        |-> (!wb_en && !st_en));
endmodule

bind sc_core sc_core_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc         (pc_o),
    .op         (instr[31:26]),
    .rs_idx     (instr[25:21]),
    .rs_val     (rd_a),
    .srcs_equal (rd_a == rd_b),
    .imm        (instr[15:0]),
    .wb_en      (wb_en_o),
    .st_en      (st_en_o)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
    localparam int LD_AW = 6;
    localparam int NV    = 21;

    typedef struct packed {
        logic [31:0] instr;
        logic        skip;
        logic        wb;
        logic [4:0]  wreg;
        logic [31:0] wdat;
        logic        st;
        logic [31:0] sadr;
        logic [31:0] sdat;
        logic [7:0]  req;
    } vec_t;

    // entry i sits at byte address i*4
    localparam vec_t TBL [NV] = '{
        '{32'h8C010010, 1'b0, 1'b1, 5'd1,  32'h12345678, 1'b0, 32'h0,  32'h0,        8'd4},  // R4 lw r1,16(r0)
        '{32'h8C020014, 1'b0, 1'b1, 5'd2,  32'hFFFFFFF0, 1'b0, 32'h0,  32'h0,        8'd4},  // R4 lw r2,20(r0)
        '{32'h00221820, 1'b0, 1'b1, 5'd3,  32'h12345668, 1'b0, 32'h0,  32'h0,        8'd3},  // R3 add
        '{32'h00222022, 1'b0, 1'b1, 5'd4,  32'h12345688, 1'b0, 32'h0,  32'h0,        8'd3},  // R3 sub
        '{32'h00222824, 1'b0, 1'b1, 5'd5,  32'h12345670, 1'b0, 32'h0,  32'h0,        8'd3},  // R3 and
        '{32'h00223025, 1'b0, 1'b1, 5'd6,  32'hFFFFFFF8, 1'b0, 32'h0,  32'h0,        8'd3},  // R3 or
        '{32'h0041382A, 1'b0, 1'b1, 5'd7,  32'h00000001, 1'b0, 32'h0,  32'h0,        8'd3},  // R3 slt neg<pos
        '{32'h0022402A, 1'b0, 1'b1, 5'd8,  32'h00000000, 1'b0, 32'h0,  32'h0,        8'd3},  // R3 slt signed
        '{32'hAC030020, 1'b0, 1'b0, 5'd0,  32'h0,        1'b1, 32'h20, 32'h12345668, 8'd5},  // R5 sw r3,32(r0)
        '{32'h8C090020, 1'b0, 1'b1, 5'd9,  32'h12345668, 1'b0, 32'h0,  32'h0,        8'd5},  // R5 load back
        '{32'h00210020, 1'b0, 1'b1, 5'd0,  32'h2468ACF0, 1'b0, 32'h0,  32'h0,        8'd7},  // R7 write r0
        '{32'h00005025, 1'b0, 1'b1, 5'd10, 32'h00000000, 1'b0, 32'h0,  32'h0,        8'd7},  // R7 r0 still zero
        '{32'h10210001, 1'b0, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0,        8'd6},  // R6 taken
        '{32'h00215820, 1'b1, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0,        8'd6},  // R6 skipped
        '{32'h10220005, 1'b0, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0,        8'd6},  // R6 not taken
        '{32'hFC221820, 1'b0, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0,        8'd8},  // R8 bad opcode
        '{32'h0022183F, 1'b0, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0,        8'd8},  // R8 bad funct
        '{32'h00210820, 1'b0, 1'b1, 5'd1,  32'h2468ACF0, 1'b0, 32'h0,  32'h0,        8'd9},  // R9 self-update
        '{32'h00206020, 1'b0, 1'b1, 5'd12, 32'h2468ACF0, 1'b0, 32'h0,  32'h0,        8'd9},  // R9 sees new
        '{32'h00016822, 1'b0, 1'b1, 5'd13, 32'hDB975310, 1'b0, 32'h0,  32'h0,        8'd3},  // R3 negative sub
        '{32'h1000FFFF, 1'b0, 1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0,        8'd6}   // R6 self loop
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ld_en = 1'b0;
    logic             ld_dmem = 1'b0;
    logic [LD_AW-1:0] ld_addr = '0;
    logic [31:0]      ld_data = '0;
    logic [31:0]      pc_o, wb_data_o, st_addr_o, st_data_o;
    logic             wb_en_o, st_en_o;
    logic [4:0]       wb_reg_o;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    sc_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_dmem   (ld_dmem),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .pc_o      (pc_o),
        .wb_en_o   (wb_en_o),
        .wb_reg_o  (wb_reg_o),
        .wb_data_o (wb_data_o),
        .st_en_o   (st_en_o),
        .st_addr_o (st_addr_o),
        .st_data_o (st_data_o)
    );

    task automatic chk(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic to_d, input int idx, input logic [31:0] val);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_dmem = to_d;
        ld_addr = LD_AW'(idx);
        ld_data = val;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < NV; i++) preload(1'b0, i, TBL[i].instr);  // R10
        preload(1'b1, 4, 32'h12345678);
        preload(1'b1, 5, 32'hFFFFFFF0);
        #1;
        // R1 reset state
        chk(1, "pc in reset", pc_o, 32'h0);
        chk(1, "wb_en in reset", {31'h0, wb_en_o}, 32'h0);
        chk(1, "st_en in reset", {31'h0, st_en_o}, 32'h0);

        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].skip) continue;
            chk(int'(TBL[i].req), "pc", pc_o, 32'(i * 4));                 // R2 / R6
            chk(int'(TBL[i].req), "wb_en", {31'h0, wb_en_o}, {31'h0, TBL[i].wb});
            if (TBL[i].wb) begin
                chk(int'(TBL[i].req), "wb_reg", {27'h0, wb_reg_o}, {27'h0, TBL[i].wreg});
                chk(int'(TBL[i].req), "wb_data", wb_data_o, TBL[i].wdat);
            end
            chk(int'(TBL[i].req), "st_en", {31'h0, st_en_o}, {31'h0, TBL[i].st});
            if (TBL[i].st) begin
                chk(int'(TBL[i].req), "st_addr", st_addr_o, TBL[i].sadr);
                chk(int'(TBL[i].req), "st_data", st_data_o, TBL[i].sdat);
            end
            step();
        end

        // R6 self-loop holds the PC
        step();
        step();
        chk(6, "pc self loop", pc_o, 32'd80);

        // R1 reset mid-run: PC returns to 0, load at 0 must not write
        @(negedge clk);
        rst = 1'b1;
        step();
        chk(1, "pc after reset", pc_o, 32'h0);
        chk(1, "wb gated in reset", {31'h0, wb_en_o}, 32'h0);

        // R10 stores kept through reset
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(10, "reload wb_data", wb_data_o, 32'h12345678);
        chk(10, "reload wb_en", {31'h0, wb_en_o}, 32'h1);
        step();
        chk(2, "pc after first", pc_o, 32'd4);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule